// File: doc/BRIEF.md
# Four-Channel Phased Switching Clock Generator

The block keeps one control register for a set of four switching converters and turns a fixed reference clock into four square-wave channel clocks. A 16-bit command word arrives with a one-cycle write strobe. The block accepts the word only when the three top bits carry its selector. It then stores a compensation-select bit, a two-bit phase mode, a two-bit frequency code and a two-bit maximum-voltage code.

The four channel clocks come from one shared divider. The divider counts a period of four equal quarters. The quarter length is 13, 8 or 5 reference cycles, which gives a divide ratio of 52, 32 or 20. Each channel is high for the first two quarters of its own shifted period. The phase mode sets the shift of each channel in whole quarters. A new frequency or phase setting is held back until the current period ends, so a channel never sees a shortened or stretched pulse. The compensation and voltage codes leave the block as static levels as soon as they are written.

Top module: `quad_phase_clkgen`

## Requirements
- R1: After reset the compensation output is 0, the voltage output is 00, all four channel clocks are high in the first cycle, and the period is 32 cycles with phase mode 00.
- R2: A word is stored only when the write strobe is high and bits 15:13 equal 011. Any other selector leaves every output unchanged. Bits 12:7 of an accepted word have no effect.
- R3: Bit 6 of an accepted word appears on the compensation output in the cycle after the write.
- R4: Bits 1:0 of an accepted word appear on the voltage output in the cycle after the write.
- R5: Bits 3:2 set the period: 00 gives 52 cycles, 01 gives 32, 10 gives 20, and 11 gives 32. Each channel is high for the first half of its period.
- R6: With phase code 00 (bits 5:4), all four channels are identical and are high in quarters 0 and 1 of the shared period.
- R7: With phase code 01, channels 0 and 1 follow the base waveform, and channels 2 and 3 are its inverse (shifted by half a period).
- R8: With phase code 10, channels 0 and 2 follow the base waveform, and channels 1 and 3 are its inverse.
- R9: With phase code 11, channel n lags channel 0 by n quarters of the period.
- R10: A written frequency or phase code takes effect only at the first period boundary after the write. Until then, the channel waveforms continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for cmd_word |
| cmd_word | input | 16 | Command word: selector, compensation, phase, frequency, voltage |
| ch_clk | output | 4 | Channel clocks, channel 0 in bit 0 |
| comp_sel | output | 1 | Stored compensation-select bit |
| vmax_sel | output | 2 | Stored maximum-voltage code |

## Verification
Some checks run on every cycle. The phase relations between the four channels are checked in each mode: equal, paired antiphase, or two channels high in quadrature. The quarter counter must stay in range and must wrap cleanly to zero. Foreign selectors must leave the register unchanged, and accepted fields must be captured. The active settings must not change away from a period boundary.

Some behaviour only the bench scenarios can show. These are the exact period length for each frequency code and the absolute position of each pulse in the period. They also include the cycle in which a written setting takes hold after a write in the middle of a period. The bench compares every output, every cycle, against a model built from the requirements.

// File: rtl/qpc_pkg.sv
// Shared types and constants for the phased clock generator.
// Assumes a fixed 16-bit command format with a 3-bit selector on top.
package qpc_pkg;
    localparam int CMD_W  = 16;
    localparam int NUM_CH = 4;
    localparam logic [2:0] SEL_TAG = 3'b011;

    typedef enum logic [1:0] {
        PH_ALIGN   = 2'b00,
        PH_PAIR_AB = 2'b01,
        PH_PAIR_AC = 2'b10,
        PH_QUAD    = 2'b11
    } phase_e;

    typedef struct packed {
        logic       comp;
        phase_e     phase;
        logic [1:0] freq;
        logic [1:0] vmax;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{comp: 1'b0, phase: PH_ALIGN, freq: 2'b01, vmax: 2'b00};
endpackage

// File: rtl/qpc_cfg_reg.sv
// Command decoder and control register.
// Captures a word when the strobe is high and the selector matches; other words are dropped.
// Assumes cmd_word is stable in the cycle cmd_wr is high.
module qpc_cfg_reg
    import qpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_word,
    output cfg_t             cfg_q
);
    logic hit;

    // Selector match for this register.
    always_comb hit = cmd_wr && (cmd_word[15:13] == SEL_TAG);

    // Store the fields of an accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= CFG_RESET;
        else if (hit)
            cfg_q <= '{comp: cmd_word[6], phase: phase_e'(cmd_word[5:4]),
                       freq: cmd_word[3:2], vmax: cmd_word[1:0]};
    end

    AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_word[15:13] != SEL_TAG) |=> $stable(cfg_q)); // R2
    AST_PAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_word[15:13] == SEL_TAG && cmd_word[12:7] != 6'd0)
        |=> (cfg_q.phase == $past(cmd_word[5:4]) && cfg_q.freq == $past(cmd_word[3:2]))); // R2
    AST_COMP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cfg_q.comp == $past(cmd_word[6])); // R3
    AST_VMAX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cfg_q.vmax == $past(cmd_word[1:0])); // R4
endmodule

// File: rtl/qpc_divider.sv
// Shared period counter: a quarter counter and a 2-bit quarter index.
// Loads the pending phase and frequency codes only on the last cycle of a period.
// Assumes Q_SLOW is the largest quarter length.
module qpc_divider
    import qpc_pkg::*;
#(
    parameter int Q_SLOW = 13,
    parameter int Q_MID  = 8,
    parameter int Q_FAST = 5,
    localparam int CNT_W = $clog2(Q_SLOW + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  phase_e     pend_phase,
    input  logic [1:0] pend_freq,
    output phase_e     act_phase,
    output logic [1:0] quarter
);
    logic [1:0]       act_freq;
    logic [CNT_W-1:0] q_cnt;
    logic [CNT_W-1:0] q_len;
    logic             last_q;
    logic             last_cycle;

    // Quarter length for the active frequency code; code 11 uses the middle rate.
    always_comb begin
        case (act_freq)
            2'b00:   q_len = CNT_W'(Q_SLOW);
            2'b10:   q_len = CNT_W'(Q_FAST);
            default: q_len = CNT_W'(Q_MID);
        endcase
    end

    // End of a quarter, and end of a whole period.
    always_comb begin
        last_q     = (q_cnt == q_len - CNT_W'(1));
        last_cycle = last_q && (quarter == 2'd3);
    end

    // Advance the quarter counter and the quarter index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_cnt   <= '0;
            quarter <= 2'd0;
        end else if (last_q) begin
            q_cnt   <= '0;
            quarter <= quarter + 2'd1;
        end else begin
            q_cnt   <= q_cnt + CNT_W'(1);
        end
    end

    // Take the pending settings only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_phase <= CFG_RESET.phase;
            act_freq  <= CFG_RESET.freq;
        end else if (last_cycle) begin
            act_phase <= pend_phase;
            act_freq  <= pend_freq;
        end
    end

    AST_QCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q_cnt < q_len); // R5
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        last_cycle |=> (quarter == 2'd0 && q_cnt == '0)); // R5
    AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !last_cycle |=> ($stable(act_phase) && $stable(act_freq))); // R10
endmodule

// File: rtl/qpc_phase_map.sv
// Maps the shared quarter index to four channel clocks.
// A channel shifted by k quarters is high while (quarter - k) mod 4 is 0 or 1.
// Assumes NUM_CH is 4.
module qpc_phase_map
    import qpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            mode,
    input  logic [1:0]        quarter,
    output logic [NUM_CH-1:0] ch_clk
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [1:0] GI = 2'(g);
        logic [1:0] lag;
        logic [1:0] rel;

        // Quarter shift of this channel in the selected mode.
        always_comb begin
            case (mode)
                PH_PAIR_AB: lag = GI[1] ? 2'd2 : 2'd0;
                PH_PAIR_AC: lag = GI[0] ? 2'd2 : 2'd0;
                PH_QUAD:    lag = GI;
                default:    lag = 2'd0;
            endcase
        end

        // High for the first half of the shifted period.
        always_comb begin
            rel       = quarter - lag;
            ch_clk[g] = ~rel[1];
        end
    end

    AST_ALIGN_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PH_ALIGN) |-> ($countones(ch_clk) == 0 || $countones(ch_clk) == NUM_CH)); // R6
    AST_PAIR_AB: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PH_PAIR_AB) |-> (ch_clk[1] == ch_clk[0] && ch_clk[3] == ch_clk[2] && ch_clk[2] != ch_clk[0])); // R7
    AST_PAIR_AC: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PH_PAIR_AC) |-> (ch_clk[2] == ch_clk[0] && ch_clk[3] == ch_clk[1] && ch_clk[1] != ch_clk[0])); // R8
    AST_QUAD_SPREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PH_QUAD) |-> ($countones(ch_clk) == 2 && ch_clk[0] != ch_clk[2] && ch_clk[1] != ch_clk[3])); // R9
endmodule

// File: rtl/quad_phase_clkgen.sv
// Top: control register plus four phased channel clocks from one divider.
// Compensation and voltage codes are static outputs; phase and frequency
// are applied at period boundaries. Assumes synchronous active-low reset.
module quad_phase_clkgen
    import qpc_pkg::*;
#(
    parameter int Q_SLOW = 13,
    parameter int Q_MID  = 8,
    parameter int Q_FAST = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [15:0] cmd_word,
    output logic [3:0]  ch_clk,
    output logic        comp_sel,
    output logic [1:0]  vmax_sel
);
    cfg_t       cfg_q;
    phase_e     act_phase;
    logic [1:0] quarter;

    qpc_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_word (cmd_word),
        .cfg_q    (cfg_q)
    );

    qpc_divider #(
        .Q_SLOW (Q_SLOW),
        .Q_MID  (Q_MID),
        .Q_FAST (Q_FAST)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_phase (cfg_q.phase),
        .pend_freq  (cfg_q.freq),
        .act_phase  (act_phase),
        .quarter    (quarter)
    );

    qpc_phase_map u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (act_phase),
        .quarter (quarter),
        .ch_clk  (ch_clk)
    );

    // Static fields leave the register unchanged.
    always_comb begin
        comp_sel = cfg_q.comp;
        vmax_sel = cfg_q.vmax;
    end
endmodule

// File: tb/quad_phase_clkgen_test.sv
`timescale 1ns/1ps
module quad_phase_clkgen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_word = 16'h0000;
    logic [3:0]  ch_clk;
    logic        comp_sel;
    logic [1:0]  vmax_sel;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // Model state, built from the requirements.
    int         pos = 0;
    logic [1:0] a_phase = 2'b00, a_freq = 2'b01;
    logic [1:0] p_phase = 2'b00, p_freq = 2'b01;
    logic       m_comp = 1'b0;
    logic [1:0] m_vmax = 2'b00;

    quad_phase_clkgen uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .ch_clk(ch_clk), .comp_sel(comp_sel), .vmax_sel(vmax_sel)
    );

    always #5 clk = ~clk;

    function automatic int qlen(input logic [1:0] f);
        case (f)
            2'b00:   return 13;
            2'b10:   return 5;
            default: return 8;
        endcase
    endfunction

    function automatic int lag_of(input logic [1:0] m, input int ch);
        case (m)
            2'b01:   return (ch >= 2) ? 2 : 0;
            2'b10:   return (ch % 2 == 1) ? 2 : 0;
            2'b11:   return ch;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] mk(input logic c, input logic [1:0] ph,
                                       input logic [1:0] fr, input logic [1:0] vm);
        return {3'b011, 6'd0, c, ph, fr, vm};
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        logic [3:0] e;
        int qi;
        qi = pos / qlen(a_freq);
        for (int c = 0; c < 4; c++) e[c] = (((qi - lag_of(a_phase, c)) % 4 + 4) % 4) < 2;
        check(ch_clk === e && comp_sel === m_comp && vmax_sel === m_vmax, "outputs",
              {ch_clk, 1'b0, comp_sel, vmax_sel}, {e, 1'b0, m_comp, m_vmax});
    endtask

    // One cycle: check at the falling edge, drive, then step the model at the rising edge.
    task automatic tick(input logic wr, input logic [15:0] w);
        check_outputs();
        cmd_wr = wr;
        cmd_word = w;
        @(posedge clk);
        if (pos == 4 * qlen(a_freq) - 1) begin
            pos = 0;
            a_phase = p_phase;
            a_freq = p_freq;
        end else pos++;
        if (wr && w[15:13] == 3'b011) begin
            p_phase = w[5:4]; p_freq = w[3:2]; m_comp = w[6]; m_vmax = w[1:0];
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 16'h0000);
    endtask

    task automatic t_reset();
        cur_req = "R1";
        check(ch_clk === 4'hF, "reset ch_clk", ch_clk, 4'hF);
        check(comp_sel === 1'b0 && vmax_sel === 2'b00, "reset static", {comp_sel, vmax_sel}, 0);
        idle(70);
    endtask

    task automatic t_decode();
        cur_req = "R2";
        tick(1'b1, 16'h2000 | 16'h007F);
        tick(1'b1, 16'hE000 | 16'h0055);
        tick(1'b0, mk(1'b1, 2'b11, 2'b10, 2'b11));
        idle(40);
        tick(1'b1, mk(1'b1, 2'b00, 2'b01, 2'b11) | 16'h1F80);
        idle(40);
    endtask

    task automatic t_static();
        cur_req = "R3";
        tick(1'b1, mk(1'b0, 2'b00, 2'b01, 2'b11));
        idle(3);
        tick(1'b1, mk(1'b1, 2'b00, 2'b01, 2'b11));
        idle(3);
        cur_req = "R4";
        tick(1'b1, mk(1'b1, 2'b00, 2'b01, 2'b10));
        idle(3);
        tick(1'b1, mk(1'b0, 2'b00, 2'b01, 2'b01));
        idle(40);
    endtask

    task automatic t_freq();
        cur_req = "R5";
        for (int f = 0; f < 4; f++) begin
            tick(1'b1, mk(1'b0, 2'b00, 2'(f), 2'b00));
            idle(3 * 52 + 60);
        end
    endtask

    task automatic t_phase();
        cur_req = "R6";
        tick(1'b1, mk(1'b0, 2'b00, 2'b10, 2'b00));
        idle(80);
        cur_req = "R7";
        tick(1'b1, mk(1'b0, 2'b01, 2'b10, 2'b00));
        idle(80);
        cur_req = "R8";
        tick(1'b1, mk(1'b0, 2'b10, 2'b10, 2'b00));
        idle(80);
        cur_req = "R9";
        tick(1'b1, mk(1'b0, 2'b11, 2'b10, 2'b00));
        idle(80);
        tick(1'b1, mk(1'b0, 2'b11, 2'b00, 2'b00));
        idle(160);
    endtask

    task automatic t_boundary();
        cur_req = "R10";
        tick(1'b1, mk(1'b0, 2'b00, 2'b01, 2'b00));
        idle(70);
        idle(11);
        tick(1'b1, mk(1'b0, 2'b01, 2'b00, 2'b00));
        idle(5);
        tick(1'b1, mk(1'b0, 2'b11, 2'b10, 2'b00));
        idle(120);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_static();
        t_freq();
        t_phase();
        t_boundary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule